// File: doc/BRIEF.md
# Floating-Point Compare Condition-Word Unit

This unit compares two 32-bit operands and returns one 32-bit condition word. Each bit of that word reports one relation between the operands, or one range test of the first operand against the interval that runs from zero to the second operand. A 2-bit type tag comes with each operand. The tag says whether the operand is a single-precision IEEE-754 value, a signed 32-bit integer or an unsigned 32-bit integer. The two operands of a pair may have different types; they are still compared by their exact numeric value.

Each operand is first unpacked into a shared internal form. That form holds a class (NaN, zero, infinity or finite), a sign, a signed exponent and a 32-bit normalized mantissa. Every single-precision value, denormals included, and every 32-bit integer fits this form without rounding. The unit then finds the signed order of the pair and encodes the condition word.

The result is registered. It appears one cycle after a valid input, with a one-cycle valid pulse. A double-precision tag cannot be served from a single word, so it raises an error flag.

Top module: `fcmp_cond_unit`

## Requirements
- R1: The tag codes are 0 single-precision float, 1 double, 2 signed integer and 3 unsigned integer. If either tag is 1, `tag_err` is 1 and `cond_word` is all zeros. This takes priority over NaN detection.
- R2: A float operand with exponent field 0xFF and a nonzero fraction is a NaN. When either operand is a NaN, and there is no tag error, `cond_word` is exactly 0x4000_0000, which means only bit 30 is set.
- R3: When neither operand is a NaN and there is no tag error, bit 31 is 1, bit 30 is 0 and bits 19..0 are 0.
- R4: For an ordered pair the relation bits are: bit 20 a==b, bit 21 a!=b, bit 22 a>b, bit 23 a<=b, bit 24 a<b, bit 25 a>=b.
- R5: For an ordered pair the range-test bits are: bit 26 (a<0 or a>b), bit 27 (0<a and a<b), bit 28 (0<=a and a<=b), bit 29 (a<=0 or a>=b).
- R6: A tag-3 operand is taken as an unsigned value, so 0xFFFF_FFFF is 4294967295.
- R7: A tag-2 operand is taken as two's complement. Integers and floats of any mix are compared exactly, with no rounding. For example, the integer 16777217 is greater than the float 16777216.0.
- R8: Float +0 and -0 compare equal to each other and to integer 0. A float infinity is greater or less than every finite value, according to its sign, and two infinities of the same sign compare equal.
- R9: Denormal floats (exponent field 0) are compared exactly. For example, 0x0000_0001 < 0x0000_0002 and 0x007F_FFFF < 0x0080_0000.
- R10: A result appears on the clock edge that follows the edge on which `in_valid` is sampled high. `out_valid` is high for exactly those cycles. While `rst` is high, `out_valid`, `cond_word` and `tag_err` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| op_a | input | 32 | First operand (a) |
| tag_a | input | 2 | Type tag of op_a |
| op_b | input | 32 | Second operand (b) |
| tag_b | input | 2 | Type tag of op_b |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| cond_word | output | 32 | Condition word |
| tag_err | output | 1 | Unsupported (double) tag seen |

## Verification
The hardest cases to reach from the ports are the exact-value comparisons at the edges of each format. These are a 25-bit integer against the nearest float, the most negative signed integer against -2^31 as a float, denormals against each other and against the smallest normal, and infinities against integer extremes. A general stimulus pattern almost never produces these pairs, so the driver applies them as targeted vectors. The expected words come from a real-valued model in the bench. It can represent every 32-bit integer and every single-precision value exactly. Back-to-back vectors and idle gaps exercise the valid timing as the scoreboard pops each result.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

    localparam int DATA_W    = 32;
    localparam int EXP_W     = 10;
    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;
    localparam int FP_BIAS   = 127;
    localparam int LZ_W      = $clog2(DATA_W) + 1;

    // condition word bit positions
    localparam int BIT_EQ        = 20;
    localparam int BIT_NE        = 21;
    localparam int BIT_GT        = 22;
    localparam int BIT_LE        = 23;
    localparam int BIT_LT        = 24;
    localparam int BIT_GE        = 25;
    localparam int BIT_OUTSIDE   = 26;
    localparam int BIT_INSIDE_OP = 27;
    localparam int BIT_INSIDE_CL = 28;
    localparam int BIT_ON_EDGE   = 29;
    localparam int BIT_UNORD     = 30;
    localparam int BIT_ORD       = 31;

    typedef enum logic [1:0] {
        TAG_SP   = 2'd0,
        TAG_DP   = 2'd1,
        TAG_SINT = 2'd2,
        TAG_UINT = 2'd3
    } tag_e;

    typedef logic signed [EXP_W-1:0] exp_t;

    // common internal form: mant bit DATA_W-1 carries weight 2**exp
    typedef struct packed {
        logic              nan;
        logic              zero;
        logic              inf;
        logic              neg;
        exp_t              exp;
        logic [DATA_W-1:0] mant;
    } unp_t;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [DATA_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = LZ_W'(DATA_W);
        hit = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!hit && v[i]) begin
                n   = LZ_W'(DATA_W - 1 - i);
                hit = 1'b1;
            end
        end
        return n;
    endfunction

    // magnitude class rank: zero < finite < infinity
    function automatic logic [1:0] mag_rank(input unp_t u);
        if (u.zero)     return 2'd0;
        else if (u.inf) return 2'd2;
        else            return 2'd1;
    endfunction

endpackage

// File: rtl/fcw_unpack.sv
module fcw_unpack
    import fcw_pkg::*;
(
    input  tag_e              tag,
    input  logic [DATA_W-1:0] raw,
    output unp_t              u,
    output logic              bad
);

    logic [FP_EXP_W-1:0]  fexp;
    logic [FP_FRAC_W-1:0] ffrac;
    logic [DATA_W-1:0]    den_pre;
    logic [DATA_W-1:0]    int_mag;
    logic [LZ_W-1:0]      den_lz;
    logic [LZ_W-1:0]      int_lz;

    assign fexp    = raw[DATA_W-2 -: FP_EXP_W];
    assign ffrac   = raw[FP_FRAC_W-1:0];
    assign den_pre = {ffrac, {(DATA_W-FP_FRAC_W){1'b0}}};
    assign den_lz  = lead_zeros(den_pre);

    // integer magnitude: two's complement for signed, raw for unsigned
    always_comb begin
        if (tag == TAG_SINT && raw[DATA_W-1]) int_mag = ~raw + 1'b1;
        else                                 int_mag = raw;
    end
    assign int_lz = lead_zeros(int_mag);

    always_comb begin
        u   = '0;
        bad = 1'b0;
        unique case (tag)
            TAG_SP: begin
                u.neg = raw[DATA_W-1];
                if (fexp == '1) begin
                    u.nan = (ffrac != '0);
                    u.inf = (ffrac == '0);
                end else if (fexp == '0) begin
                    if (ffrac == '0) begin
                        u.zero = 1'b1;
                    end else begin
                        u.mant = den_pre << den_lz;
                        u.exp  = exp_t'(0 - FP_BIAS) - exp_t'(den_lz);
                    end
                end else begin
                    u.mant = {1'b1, ffrac, {(DATA_W-FP_FRAC_W-1){1'b0}}};
                    u.exp  = exp_t'(fexp) - exp_t'(FP_BIAS);
                end
            end
            TAG_DP: begin
                bad = 1'b1;
            end
            TAG_SINT, TAG_UINT: begin
                u.neg  = (tag == TAG_SINT) && raw[DATA_W-1];
                u.zero = (int_mag == '0);
                u.mant = int_mag << int_lz;
                u.exp  = exp_t'(DATA_W - 1) - exp_t'(int_lz);
            end
            default: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/fcw_order.sv
module fcw_order
    import fcw_pkg::*;
(
    input  unp_t a,
    input  unp_t b,
    output rel_t rel,
    output logic a_below0,
    output logic a_above0,
    output logic any_nan
);

    logic [1:0] ra, rb;
    logic       mag_gt, mag_lt, mag_eq;
    logic       sa, sb;

    assign ra = mag_rank(a);
    assign rb = mag_rank(b);

    // unsigned magnitude order
    always_comb begin
        mag_gt = 1'b0;
        mag_lt = 1'b0;
        if (ra != rb) begin
            mag_gt = (ra > rb);
            mag_lt = (ra < rb);
        end else if (ra == 2'd1) begin
            if (a.exp != b.exp) begin
                mag_gt = (a.exp > b.exp);
                mag_lt = (a.exp < b.exp);
            end else begin
                mag_gt = (a.mant > b.mant);
                mag_lt = (a.mant < b.mant);
            end
        end
        mag_eq = !mag_gt && !mag_lt;
    end

    // effective signs: zero is never negative
    assign sa = a.neg && !a.zero;
    assign sb = b.neg && !b.zero;

    always_comb begin
        if (sa != sb) begin
            rel.gt = sb;
            rel.lt = sa;
            rel.eq = 1'b0;
        end else if (!sa) begin
            rel.gt = mag_gt;
            rel.lt = mag_lt;
            rel.eq = mag_eq;
        end else begin
            rel.gt = mag_lt;
            rel.lt = mag_gt;
            rel.eq = mag_eq;
        end
    end

    assign a_below0 = sa;
    assign a_above0 = !a.zero && !a.neg;
    assign any_nan  = a.nan || b.nan;

endmodule

// File: rtl/fcw_encode.sv
module fcw_encode
    import fcw_pkg::*;
(
    input  rel_t              rel,
    input  logic              a_below0,
    input  logic              a_above0,
    input  logic              any_nan,
    input  logic              err,
    output logic [DATA_W-1:0] word
);

    always_comb begin
        word = '0;
        if (err) begin
            word = '0;
        end else if (any_nan) begin
            word[BIT_UNORD] = 1'b1;
        end else begin
            word[BIT_ORD]       = 1'b1;
            word[BIT_EQ]        = rel.eq;
            word[BIT_NE]        = !rel.eq;
            word[BIT_GT]        = rel.gt;
            word[BIT_LE]        = !rel.gt;
            word[BIT_LT]        = rel.lt;
            word[BIT_GE]        = !rel.lt;
            word[BIT_OUTSIDE]   = a_below0 || rel.gt;
            word[BIT_INSIDE_OP] = a_above0 && rel.lt;
            word[BIT_INSIDE_CL] = !a_below0 && !rel.gt;
            word[BIT_ON_EDGE]   = !a_above0 || !rel.lt;
        end
    end

endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
    import fcw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] op_a,
    input  logic [1:0]  tag_a,
    input  logic [31:0] op_b,
    input  logic [1:0]  tag_b,
    output logic        out_valid,
    output logic [31:0] cond_word,
    output logic        tag_err
);

    localparam int N_OPS = 2;

    logic [DATA_W-1:0] ops  [N_OPS];
    tag_e              tags [N_OPS];
    unp_t              unp  [N_OPS];
    logic              bad  [N_OPS];

    assign ops[0]  = op_a;
    assign ops[1]  = op_b;
    assign tags[0] = tag_e'(tag_a);
    assign tags[1] = tag_e'(tag_b);

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_unpack
        fcw_unpack u_unpack (
            .tag (tags[gi]),
            .raw (ops[gi]),
            .u   (unp[gi]),
            .bad (bad[gi])
        );
    end

    rel_t              rel;
    logic              a_below0, a_above0, any_nan;
    logic              err_c;
    logic [DATA_W-1:0] word_c;

    fcw_order u_order (
        .a        (unp[0]),
        .b        (unp[1]),
        .rel      (rel),
        .a_below0 (a_below0),
        .a_above0 (a_above0),
        .any_nan  (any_nan)
    );

    assign err_c = bad[0] || bad[1];

    fcw_encode u_encode (
        .rel      (rel),
        .a_below0 (a_below0),
        .a_above0 (a_above0),
        .any_nan  (any_nan),
        .err      (err_c),
        .word     (word_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cond_word <= '0;
            tag_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cond_word <= word_c;
                tag_err   <= err_c;
            end
        end
    end

    // R1: error forces an all-zero word
    a_r1_err_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid && tag_err |-> cond_word == '0);

    // R2: unordered indicator stands alone
    a_r2_nan_alone: assert property (@(posedge clk) disable iff (rst)
        out_valid && cond_word[BIT_UNORD] |-> cond_word == 32'h4000_0000);

    // R3: exactly one of ordered/unordered, low bits clear
    a_r3_ord_xor: assert property (@(posedge clk) disable iff (rst)
        out_valid && !tag_err |-> (cond_word[BIT_ORD] ^ cond_word[BIT_UNORD])
                                  && cond_word[19:0] == '0);

    // R4: exactly one of lt/eq/gt, complements consistent
    a_r4_one_rel: assert property (@(posedge clk) disable iff (rst)
        out_valid && cond_word[BIT_ORD] |->
            $countones({cond_word[BIT_LT], cond_word[BIT_EQ], cond_word[BIT_GT]}) == 1
            && cond_word[BIT_NE] != cond_word[BIT_EQ]
            && cond_word[BIT_LE] != cond_word[BIT_GT]
            && cond_word[BIT_GE] != cond_word[BIT_LT]);

    // R5: range tests imply the matching plain relations
    a_r5_range_imp: assert property (@(posedge clk) disable iff (rst)
        out_valid && cond_word[BIT_ORD] |->
            (!cond_word[BIT_INSIDE_OP] || cond_word[BIT_LT])
            && (!cond_word[BIT_INSIDE_CL] || cond_word[BIT_LE])
            && (!cond_word[BIT_GT] || cond_word[BIT_OUTSIDE])
            && (!cond_word[BIT_GE] || cond_word[BIT_ON_EDGE]));

    // R10: valid follows input by one cycle
    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: tb/tb_fcmp_cond_unit.sv
module tb_fcmp_cond_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic [1:0]  tag_a, tag_b;
    logic        out_valid;
    logic [31:0] cond_word;
    logic        tag_err;

    always #10 clk = ~clk;  // 50 MHz

    fcmp_cond_unit dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .tag_a     (tag_a),
        .op_b      (op_b),
        .tag_b     (tag_b),
        .out_valid (out_valid),
        .cond_word (cond_word),
        .tag_err   (tag_err)
    );

    typedef struct {
        logic [31:0] word;
        logic        err;
        string       req;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    function automatic real p2(input int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    // value model; infinity stands as +-1e300
    function automatic real to_real(input logic [31:0] v, input logic [1:0] t, output bit nan);
        real r;
        nan = 0;
        r   = 0.0;
        case (t)
            2'd0: begin
                if (v[30:23] == 8'hFF) begin
                    if (v[22:0] != 0) nan = 1;
                    r = 1.0e300;
                end else if (v[30:23] == 0) begin
                    r = real'(v[22:0]) * p2(-149);
                end else begin
                    r = real'({1'b1, v[22:0]}) * p2(int'(v[30:23]) - 150);
                end
                if (v[31]) r = -r;
            end
            2'd2: r = real'($signed(v));
            default: r = real'(longint'({32'b0, v}));
        endcase
        return r;
    endfunction

    function automatic logic [31:0] model(input real x, input real y);
        logic [31:0] w = 32'h8000_0000;
        w[20] = (x == y);
        w[21] = (x != y);
        w[22] = (x > y);
        w[23] = (x <= y);
        w[24] = (x < y);
        w[25] = (x >= y);
        w[26] = (x < 0.0) || (x > y);
        w[27] = (x > 0.0) && (x < y);
        w[28] = (x >= 0.0) && (x <= y);
        w[29] = (x <= 0.0) || (x >= y);
        return w;
    endfunction

    task automatic apply(input logic [31:0] a, input logic [1:0] ta,
                         input logic [31:0] b, input logic [1:0] tb,
                         input string req);
        item_t it;
        bit    na, nb;
        real   x, y;
        x = to_real(a, ta, na);
        y = to_real(b, tb, nb);
        it.req = req;
        if (ta == 2'd1 || tb == 2'd1) begin
            it.err  = 1'b1;
            it.word = 32'h0;
        end else if (na || nb) begin
            it.err  = 1'b0;
            it.word = 32'h4000_0000;
        end else begin
            it.err  = 1'b0;
            it.word = model(x, y);
        end
        @(negedge clk);
        in_valid = 1'b1;
        op_a = a; tag_a = ta;
        op_b = b; tag_b = tb;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R10: out_valid=1 expected 0 (no pending item)");
                end else begin
                    item_t e;
                    e = q.pop_front();
                    n_checks++;
                    if (cond_word !== e.word || tag_err !== e.err) begin
                        n_fail++;
                        $display("FAIL %s: word=%h err=%b expected word=%h err=%b",
                                 e.req, cond_word, tag_err, e.word, e.err);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0;
        op_a = 0; op_b = 0; tag_a = 0; tag_b = 0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || cond_word !== 32'h0 || tag_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: v=%b w=%h e=%b expected 0 0 0", out_valid, cond_word, tag_err);
        end
        rst = 1'b0;

        // R4: float relations, back-to-back
        apply(32'h3F80_0000, 2'd0, 32'h4000_0000, 2'd0, "R4 1.0<2.0");
        apply(32'h4000_0000, 2'd0, 32'h4000_0000, 2'd0, "R4 2.0==2.0");
        apply(32'hBF80_0000, 2'd0, 32'hC000_0000, 2'd0, "R4 -1>-2");
        apply(32'h0000_0005, 2'd2, 32'hFFFF_FFFD, 2'd2, "R4 int 5>-3");
        idle(2);
        // R5: range tests
        apply(32'hBF00_0000, 2'd0, 32'h4040_0000, 2'd0, "R5 below0");
        apply(32'h3F00_0000, 2'd0, 32'h4040_0000, 2'd0, "R5 inside");
        apply(32'h0000_0000, 2'd2, 32'h40A0_0000, 2'd0, "R5 at zero");
        apply(32'h4040_0000, 2'd0, 32'h4040_0000, 2'd0, "R5 at top");
        apply(32'h40A0_0000, 2'd0, 32'h4040_0000, 2'd0, "R5 above");
        apply(32'h3F00_0000, 2'd0, 32'hBF00_0000, 2'd0, "R5 empty range");
        idle(1);
        // R3 with an R8 zero pair
        apply(32'h0000_0000, 2'd0, 32'h8000_0000, 2'd0, "R8 +0==-0");
        apply(32'h8000_0000, 2'd0, 32'h0000_0000, 2'd3, "R8 -0==uint0");
        apply(32'h7F80_0000, 2'd0, 32'h7F7F_FFFF, 2'd0, "R8 +inf>max");
        apply(32'hFF80_0000, 2'd0, 32'h8000_0000, 2'd2, "R8 -inf<intmin");
        apply(32'h7F80_0000, 2'd0, 32'h7F80_0000, 2'd0, "R8 inf==inf");
        // R2: NaN
        apply(32'h7FC0_0000, 2'd0, 32'h3F80_0000, 2'd0, "R2 nan a");
        apply(32'h3F80_0000, 2'd0, 32'hFF80_0001, 2'd0, "R2 nan b");
        apply(32'h7FC0_0000, 2'd3, 32'h0000_0001, 2'd3, "R2 uint not nan");
        // R6: unsigned
        apply(32'hFFFF_FFFF, 2'd3, 32'hFFFF_FFFF, 2'd2, "R6 umax>-1");
        apply(32'h8000_0000, 2'd3, 32'h4F00_0000, 2'd0, "R6 2^31==2^31f");
        apply(32'hFFFF_FFFF, 2'd3, 32'h4F80_0000, 2'd0, "R6 umax<2^32f");
        // R7: exact mixed
        apply(32'h0100_0001, 2'd2, 32'h4B80_0000, 2'd0, "R7 2^24+1>2^24f");
        apply(32'h8000_0000, 2'd2, 32'hCF00_0000, 2'd0, "R7 intmin==-2^31f");
        apply(32'hFFFF_FFFF, 2'd2, 32'hBF80_0000, 2'd0, "R7 -1==-1.0");
        idle(3);
        // R9: denormals
        apply(32'h0000_0001, 2'd0, 32'h0000_0002, 2'd0, "R9 den1<den2");
        apply(32'h0000_0001, 2'd0, 32'h0000_0000, 2'd0, "R9 den>0");
        apply(32'h007F_FFFF, 2'd0, 32'h0080_0000, 2'd0, "R9 maxden<minnorm");
        apply(32'h8000_0001, 2'd0, 32'h0000_0000, 2'd2, "R9 -den<0");
        // R1: errors
        apply(32'h3F80_0000, 2'd1, 32'h3F80_0000, 2'd0, "R1 tag a dp");
        apply(32'h3F80_0000, 2'd0, 32'h0000_0001, 2'd1, "R1 tag b dp");
        apply(32'h7FC0_0000, 2'd0, 32'h0000_0000, 2'd1, "R1 err over nan");
        apply(32'h3F80_0000, 2'd0, 32'h3F80_0000, 2'd0, "R1 recovery");
        idle(4);

        n_checks++;
        if (q.size() != 0 || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 drain: pending=%0d out_valid=%b expected 0 0", q.size(), out_valid);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule